// File: doc/BRIEF.md
# SCL Timing Generator

This block produces the clock-line timing for an I2C master. A fast source clock is divided by a programmable prescaler into ticks. Three tick counts shape each SCL period: a high count, a low count and a full-cycle count. When the cycle count exceeds the sum of the other two, the extra ticks form a hold/setup slot. The slot follows the low phase, and SCL stays low during it. After the slot the block releases SCL. It then waits until the line reads back high, so a slave that holds SCL low stretches the clock. After that it counts the high phase.

A bit-level engine sits beside this block. It uses four one-cycle strobes to place SDA changes and to sample SDA:
- low-phase start
- SDA change point
- high-phase start, which is the sample point
- end of cycle

The block drives SCL through an open-drain enable, where 1 pulls the line low. The counts arrive packed in one configuration word. The prescaler value comes separately, and the block is switched on by its own enable. A configuration is captured when a low phase begins, so it holds for a whole period.

Top module: `scl_timing_gen`

## Requirements
- R1: The configuration word holds three 10-bit counts: high count in bits 29:20, low count in bits 19:10, cycle count in bits 9:0.
- R2: With P the effective prescaler, SCL is driven low (`scl_oe`=1) for (low + slot) * P clock cycles each period. The high phase lasts high * P cycles.
- R3: The slot equals cycle - high - low when cycle is larger than high + low; otherwise the slot is zero and SCL is released directly after the low phase.
- R4: After release, the high phase starts at the first clock edge that samples `scl_in` high. A line held low delays `stb_high` by exactly the time it stays low.
- R5: A prescaler value of 0 behaves as 1.
- R6: A high or low count of 0 behaves as 1.
- R7: Each strobe lasts one cycle and appears at a fixed point:
  - `stb_low` in the first cycle of each low phase;
  - `stb_sda` once per period, in the first cycle after the low phase;
  - `stb_high` in the first cycle of the high phase;
  - `stb_end` together with `stb_low` whenever a high phase ends.
- R8: From the cycle after `en` falls, SCL is released and no strobe is produced. Raising `en` starts a low phase on the next cycle, with `stb_low` and without `stb_end`.
- R9: The counts and the prescaler are captured when a low phase starts. A change made during a period takes effect from the next period.
- R10: Reset leaves SCL released and all strobes low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Source clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| en | input | 1 | Block enable; low releases SCL |
| cfg_div | input | 8 | Prescaler value (0 behaves as 1) |
| cfg_word | input | 32 | Packed high/low/cycle counts |
| scl_in | input | 1 | SCL read back from the pad |
| scl_oe | output | 1 | 1 pulls SCL low |
| stb_low | output | 1 | Low phase starts |
| stb_sda | output | 1 | SDA may change |
| stb_high | output | 1 | High phase starts, sample SDA |
| stb_end | output | 1 | Period completed |

## Verification
The outputs come from registers. Each result is due one clock after the edge that decides it:
- `stb_low` and `scl_oe` appear one cycle after `en` rises;
- `stb_high` appears one cycle after the first edge that sees the line high;
- an enable drop clears every output one cycle later.

The bench keeps a countdown model of the phases that is updated at every rising edge. It compares all five outputs at the following falling edge, so every expectation is placed on the exact cycle the registers switch. Period lengths are also measured by counting falling edges between strobes. These counts are checked against (low+slot)*P+1 and high*P for the standard, fast, fast-plus and degenerate configurations.

// File: rtl/scl_timing_pkg.sv
package scl_timing_pkg;
   typedef enum logic [2:0] {
      PH_IDLE = 3'd0,
      PH_LOW  = 3'd1,
      PH_SLOT = 3'd2,
      PH_WAIT = 3'd3,
      PH_HIGH = 3'd4
   } scl_phase_e;

   function automatic logic is_driven(input scl_phase_e ph);
      return (ph == PH_LOW) || (ph == PH_SLOT);
   endfunction
endpackage

// File: rtl/scl_cfg_latch.sv
module scl_cfg_latch #(
   parameter int CNT_W = 10,
   parameter int DIV_W = 8,
   parameter int CFG_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CFG_W-1:0] cfg_word,
   input  logic [DIV_W-1:0] cfg_div,
   output logic [CNT_W-1:0] hi_ticks,
   output logic [CNT_W-1:0] lo_ticks,
   output logic [CNT_W-1:0] slot_ticks,
   output logic [DIV_W-1:0] div_eff
);
   localparam int HI_LSB = 2 * CNT_W;
   localparam int LO_LSB = CNT_W;
   localparam int CY_LSB = 0;
   localparam logic [CNT_W-1:0] ONE_C = CNT_W'(1);
   localparam logic [DIV_W-1:0] ONE_D = DIV_W'(1);

   logic [CNT_W-1:0] raw_hi, raw_lo, raw_cy;
   logic [CNT_W-1:0] hi_c, lo_c, slot_c;
   logic [CNT_W:0]   sum_c, cy_ext;
   logic [DIV_W-1:0] div_c;

   always_comb begin
      raw_hi = cfg_word[HI_LSB +: CNT_W];
      raw_lo = cfg_word[LO_LSB +: CNT_W];
      raw_cy = cfg_word[CY_LSB +: CNT_W];
      hi_c   = (raw_hi == '0) ? ONE_C : raw_hi;
      lo_c   = (raw_lo == '0) ? ONE_C : raw_lo;
      sum_c  = {1'b0, hi_c} + {1'b0, lo_c};
      cy_ext = {1'b0, raw_cy};
      slot_c = (cy_ext > sum_c) ? CNT_W'(cy_ext - sum_c) : '0;
      div_c  = (cfg_div == '0) ? ONE_D : cfg_div;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hi_ticks   <= ONE_C;
         lo_ticks   <= ONE_C;
         slot_ticks <= '0;
         div_eff    <= ONE_D;
      end else if (load) begin
         hi_ticks   <= hi_c;
         lo_ticks   <= lo_c;
         slot_ticks <= slot_c;
         div_eff    <= div_c;
      end
   end
endmodule

// File: rtl/scl_prescaler.sv
module scl_prescaler #(
   parameter int DIV_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic [DIV_W-1:0] div_eff,
   output logic             tick
);
   localparam logic [DIV_W-1:0] ONE_D = DIV_W'(1);

   logic [DIV_W-1:0] pre_cnt;

   assign tick = run && (pre_cnt == div_eff - ONE_D);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      pre_cnt <= '0;
      else if (!run)   pre_cnt <= '0;
      else if (tick)   pre_cnt <= '0;
      else             pre_cnt <= pre_cnt + ONE_D;
   end
endmodule

// File: rtl/scl_phase_fsm.sv
module scl_phase_fsm
   import scl_timing_pkg::*;
#(
   parameter int CNT_W      = 10,
   parameter bit STRETCH_EN = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic             tick,
   input  logic             scl_in,
   input  logic [CNT_W-1:0] hi_ticks,
   input  logic [CNT_W-1:0] lo_ticks,
   input  logic [CNT_W-1:0] slot_ticks,
   output scl_phase_e       phase,
   output logic             load,
   output logic             run,
   output logic             stb_low,
   output logic             stb_sda,
   output logic             stb_high,
   output logic             stb_end
);
   localparam logic [CNT_W-1:0] ONE_C = CNT_W'(1);

   scl_phase_e       nxt;
   logic [CNT_W-1:0] tcnt, limit;
   logic             last_tick, high_ok;
   logic             s_low, s_sda, s_high, s_end;

   generate
      if (STRETCH_EN) begin : g_stretch
         assign high_ok = scl_in;
      end else begin : g_free
         assign high_ok = 1'b1;
      end
   endgenerate

   always_comb begin
      unique case (phase)
         PH_LOW:  limit = lo_ticks;
         PH_SLOT: limit = slot_ticks;
         PH_HIGH: limit = hi_ticks;
         default: limit = ONE_C;
      endcase
   end

   assign run       = (phase == PH_LOW) || (phase == PH_SLOT) || (phase == PH_HIGH);
   assign last_tick = tick && (tcnt == limit - ONE_C);

   always_comb begin
      nxt    = phase;
      load   = 1'b0;
      s_low  = 1'b0;
      s_sda  = 1'b0;
      s_high = 1'b0;
      s_end  = 1'b0;
      if (!en) begin
         nxt = PH_IDLE;
      end else begin
         unique case (phase)
            PH_IDLE: begin
               nxt   = PH_LOW;
               load  = 1'b1;
               s_low = 1'b1;
            end
            PH_LOW: if (last_tick) begin
               s_sda = 1'b1;
               nxt   = (slot_ticks != '0) ? PH_SLOT : PH_WAIT;
            end
            PH_SLOT: if (last_tick) nxt = PH_WAIT;
            PH_WAIT: if (high_ok) begin
               nxt    = PH_HIGH;
               s_high = 1'b1;
            end
            PH_HIGH: if (last_tick) begin
               nxt   = PH_LOW;
               load  = 1'b1;
               s_low = 1'b1;
               s_end = 1'b1;
            end
            default: nxt = PH_IDLE;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase    <= PH_IDLE;
         tcnt     <= '0;
         stb_low  <= 1'b0;
         stb_sda  <= 1'b0;
         stb_high <= 1'b0;
         stb_end  <= 1'b0;
      end else begin
         phase    <= nxt;
         if (nxt != phase) tcnt <= '0;
         else if (tick)    tcnt <= tcnt + ONE_C;
         stb_low  <= s_low;
         stb_sda  <= s_sda;
         stb_high <= s_high;
         stb_end  <= s_end;
      end
   end
endmodule

// File: rtl/scl_timing_gen.sv
module scl_timing_gen
   import scl_timing_pkg::*;
#(
   parameter int CNT_W      = 10,
   parameter int DIV_W      = 8,
   parameter int CFG_W      = 32,
   parameter bit STRETCH_EN = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic [DIV_W-1:0] cfg_div,
   input  logic [CFG_W-1:0] cfg_word,
   input  logic             scl_in,
   output logic             scl_oe,
   output logic             stb_low,
   output logic             stb_sda,
   output logic             stb_high,
   output logic             stb_end
);
   generate
      if (3 * CNT_W > CFG_W) begin : g_bad_cfg
         $error("configuration word too narrow for three counts");
      end
      if (CNT_W < 2 || DIV_W < 1) begin : g_bad_w
         $error("counter widths out of range");
      end
   endgenerate

   scl_phase_e       phase;
   logic             load, run, tick;
   logic [CNT_W-1:0] hi_ticks, lo_ticks, slot_ticks;
   logic [DIV_W-1:0] div_eff;

   scl_cfg_latch #(.CNT_W(CNT_W), .DIV_W(DIV_W), .CFG_W(CFG_W)) u_cfg (
      .clk(clk), .rst_n(rst_n), .load(load), .cfg_word(cfg_word),
      .cfg_div(cfg_div), .hi_ticks(hi_ticks), .lo_ticks(lo_ticks),
      .slot_ticks(slot_ticks), .div_eff(div_eff)
   );

   scl_prescaler #(.DIV_W(DIV_W)) u_pre (
      .clk(clk), .rst_n(rst_n), .run(run), .div_eff(div_eff), .tick(tick)
   );

   scl_phase_fsm #(.CNT_W(CNT_W), .STRETCH_EN(STRETCH_EN)) u_fsm (
      .clk(clk), .rst_n(rst_n), .en(en), .tick(tick), .scl_in(scl_in),
      .hi_ticks(hi_ticks), .lo_ticks(lo_ticks), .slot_ticks(slot_ticks),
      .phase(phase), .load(load), .run(run),
      .stb_low(stb_low), .stb_sda(stb_sda), .stb_high(stb_high), .stb_end(stb_end)
   );

   assign scl_oe = is_driven(phase);
endmodule

// File: rtl/scl_timing_chk.sv
module scl_timing_chk (
   input logic clk,
   input logic rst_n,
   input logic en,
   input logic scl_in,
   input logic scl_oe,
   input logic stb_low,
   input logic stb_sda,
   input logic stb_high,
   input logic stb_end
);
   // R8
   disabled_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> !scl_oe && !stb_low && !stb_sda && !stb_high && !stb_end);
   // R4
   high_after_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
      stb_high |-> $past(scl_in) && !$past(scl_oe) && !scl_oe);
   // R2
   drive_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(scl_oe) |-> stb_low);
   // R7
   end_with_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      stb_end |-> stb_low && scl_oe);
   // R7
   strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({stb_low, stb_sda, stb_high}));
   // R7
   strobe_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      stb_high |=> !stb_high);
endmodule

bind scl_timing_gen scl_timing_chk u_chk (
   .clk(clk), .rst_n(rst_n), .en(en), .scl_in(scl_in), .scl_oe(scl_oe),
   .stb_low(stb_low), .stb_sda(stb_sda), .stb_high(stb_high), .stb_end(stb_end)
);

// File: tb/scl_timing_gen_tb.sv
module scl_timing_gen_tb;
   localparam int CLK_PERIOD = 10;
   localparam int WATCHDOG   = 150000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        en = 1'b0;
   logic [7:0]  cfg_div = 8'd0;
   logic [31:0] cfg_word = 32'd0;
   logic        hold = 1'b0;
   logic        scl_in;
   logic        scl_oe, stb_low, stb_sda, stb_high, stb_end;

   int n_cmp = 0, n_bad = 0, cycles = 0;
   bit done = 1'b0;

   assign scl_in = !scl_oe && !hold;

   always #(CLK_PERIOD/2) clk = ~clk;

   scl_timing_gen u_dut (
      .clk(clk), .rst_n(rst_n), .en(en), .cfg_div(cfg_div), .cfg_word(cfg_word),
      .scl_in(scl_in), .scl_oe(scl_oe), .stb_low(stb_low), .stb_sda(stb_sda),
      .stb_high(stb_high), .stb_end(stb_end)
   );

   // Behavioural model: phase 0 idle, 1 low, 2 slot, 3 wait, 4 high
   int m_ph = 0, m_rem = 0, m_hi = 1, m_lo = 1, m_slot = 0, m_p = 1;
   bit m_low = 0, m_sda = 0, m_high = 0, m_end = 0;

   task automatic m_start();
      int h, l, c;
      h = (cfg_word >> 20) & 1023;
      l = (cfg_word >> 10) & 1023;
      c = cfg_word & 1023;
      m_hi = (h == 0) ? 1 : h;
      m_lo = (l == 0) ? 1 : l;
      m_slot = (c > m_hi + m_lo) ? c - m_hi - m_lo : 0;
      m_p = (cfg_div == 0) ? 1 : int'(cfg_div);
      m_ph = 1;
      m_rem = m_lo * m_p;
      m_low = 1;
   endtask

   always @(posedge clk) begin
      bit line;
      line = !(m_ph == 1 || m_ph == 2) && !hold;
      m_low = 0; m_sda = 0; m_high = 0; m_end = 0;
      if (!rst_n || !en) m_ph = 0;
      else begin
         case (m_ph)
            0: m_start();
            1: begin
               m_rem--;
               if (m_rem == 0) begin
                  m_sda = 1;
                  if (m_slot > 0) begin m_ph = 2; m_rem = m_slot * m_p; end
                  else m_ph = 3;
               end
            end
            2: begin m_rem--; if (m_rem == 0) m_ph = 3; end
            3: if (line) begin m_ph = 4; m_rem = m_hi * m_p; m_high = 1; end
            default: begin
               m_rem--;
               if (m_rem == 0) begin m_end = 1; m_start(); end
            end
         endcase
      end
   end

   always @(negedge clk) begin
      logic [4:0] act, exp;
      cycles++;
      act = {scl_oe, stb_low, stb_sda, stb_high, stb_end};
      exp = {(m_ph == 1 || m_ph == 2), m_low, m_sda, m_high, m_end};
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL R2 R7 cycle %0d: actual=%b expected=%b", cycles, act, exp);
      end
      if (cycles > WATCHDOG && !done) begin
         n_bad++;
         $display("FAIL watchdog: actual=%0d cycles expected<=%0d", cycles, WATCHDOG);
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   task automatic chk(input string req, input int act, input int exp);
      n_cmp++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic set_cfg(input int p, input int hi, input int lo, input int cy);
      cfg_div  = 8'(p);
      cfg_word = {2'b00, 10'(hi), 10'(lo), 10'(cy)};
   endtask

   task automatic wait_low();
      do @(negedge clk); while (!stb_low);
   endtask

   task automatic measure_here(output int a, output int b, output int sda);
      a = 0; b = 0; sda = 0;
      do begin
         a++;
         if (stb_sda) sda++;
         if (a == 40 && hold) hold = 1'b0;
         @(negedge clk);
      end while (!stb_high);
      do begin b++; @(negedge clk); end while (!stb_low);
   endtask

   task automatic run_cfg(input string req, input int p, input int hi, input int lo,
                          input int cy, input int ea, input int eb);
      int a, b, s;
      en = 1'b0;
      set_cfg(p, hi, lo, cy);
      repeat (2) @(negedge clk);
      en = 1'b1;
      wait_low();
      measure_here(a, b, s);
      chk({req, " low+slot"}, a, ea);
      chk({req, " high"}, b, eb);
   endtask

   initial begin
      int a, b, s;
      repeat (4) @(negedge clk);
      // R10 reset state
      chk("R10 scl_oe", scl_oe, 0);
      chk("R10 strobes", {stb_low, stb_sda, stb_high, stb_end}, 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R10 idle after reset", scl_oe, 0);

      // R1 R2 R3: standard mode, slot 5
      run_cfg("R1 R2 std", 7, 10, 11, 26, 113, 70);
      chk("R7 stb_end at period end", stb_end, 1);
      run_cfg("R2 fast", 2, 5, 12, 24, 39, 10);
      run_cfg("R1 fastplus", 1, 3, 9, 18, 16, 3);
      // R3 cycle below high+low: no slot
      run_cfg("R3 no slot", 3, 4, 6, 5, 19, 12);
      // R5 prescaler 0
      run_cfg("R5 div0", 0, 2, 3, 5, 4, 2);
      // R6 zero counts
      run_cfg("R6 zero counts", 2, 0, 0, 0, 3, 2);

      // R7 strobes per period
      en = 1'b0; set_cfg(1, 3, 9, 18); repeat (2) @(negedge clk); en = 1'b1;
      wait_low();
      chk("R8 first low has no stb_end", stb_end, 0);
      measure_here(a, b, s);
      chk("R7 one stb_sda per period", s, 1);
      chk("R7 stb_end with stb_low", stb_end, 1);

      // R4 stretch: line held low until count 40
      hold = 1'b1;
      measure_here(a, b, s);
      chk("R4 stretched low", a, 40);
      chk("R4 high after stretch", b, 3);

      // R9 change mid-period
      set_cfg(2, 5, 12, 24);
      measure_here(a, b, s);
      chk("R9 old cfg low", a, 16);
      chk("R9 old cfg high", b, 3);
      measure_here(a, b, s);
      chk("R9 new cfg low", a, 39);
      chk("R9 new cfg high", b, 10);

      // R8 disable mid-low
      repeat (3) @(negedge clk);
      en = 1'b0;
      for (int i = 0; i < 8; i++) begin
         @(negedge clk);
         chk("R8 released", scl_oe, 0);
         chk("R8 no strobes", {stb_low, stb_sda, stb_high, stb_end}, 0);
      end
      en = 1'b1;
      @(negedge clk);
      chk("R8 restart stb_low", stb_low, 1);
      chk("R8 restart drives", scl_oe, 1);
      chk("R8 restart no stb_end", stb_end, 0);
      repeat (20) @(negedge clk);

      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule